// File: doc/BRIEF.md
# Bridge Memory Window Address Decoder

This block sits in a two-port bus bridge and decides where each memory transaction goes. It holds two forwarding windows. The first is a 32-bit window for memory-mapped I/O. The second is a prefetchable window that can reach 64-bit addresses. Configuration software programs the windows through a small register port with byte enables.

Each window has a 1 MB granularity. The programmed base is extended downward with zero bits and the programmed limit is extended upward with one bits. A window is closed when its base is above its limit.

On the decode side the block takes a strobed address, the side it arrived on, and whether it was a dual-address-cycle transfer. One clock later it returns a route code and two window-hit flags. Requests from the primary side are forwarded downstream when they hit a window. Requests from the secondary side are forwarded upstream when they miss both windows. In all other cases the request is ignored.

Top module: `bridge_win_decode`

## Requirements
- R1: After reset, the dword at offset 20h reads 0000_0000h, the dword at 24h reads 0000_FFF0h, and the dwords at 28h and 2Ch read 0. Decode outputs are 0. The I/O window then covers 0000_0000h to 000F_FFFFh, and the prefetchable window is closed.
- R2: The dword at 20h holds the I/O base in bits [15:0] and the I/O limit in bits [31:16]. The dword at 24h holds the prefetchable base and limit in the same layout. In each 16-bit half, bits [15:4] give address bits [31:20], and bits [3:0] always read 0 whatever is written.
- R3: Dword 28h holds the upper 32 base bits of the prefetchable window and dword 2Ch holds its upper 32 limit bits. Both are fully writable.
- R4: Byte enable bit n gates data byte n (bits 8n+7..8n). Bytes whose enable is low keep their old value.
- R5: An address hits a window when it lies between the effective base (programmed bits, then 20 zero bits) and the effective limit (programmed bits, then 20 one bits). Both ends are inclusive.
- R6: A window whose programmed base is greater than its programmed limit matches no address.
- R7: A dual-address-cycle request never hits the I/O window.
- R8: A single-address-cycle request is compared with its upper 32 address bits taken as zero, whatever is driven on them. So it can hit the prefetchable window only when the upper base is 0.
- R9: The route code is 00 for ignore, 01 for forward downstream and 10 for forward upstream. The code 11 never appears.
- R10: A primary-side request gets route 01 if it hits either window and 00 otherwise.
- R11: A secondary-side request gets route 00 if it hits either window and 10 otherwise.
- R12: out_valid, out_route, out_hit_pf and out_hit_mmio are registered. They reflect the request strobed on the previous clock edge. When no request was strobed, all four are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset (dword aligned) |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_rdata | output | 32 | Read data for cfg_addr (combinational) |
| in_valid | input | 1 | Request address strobe |
| in_addr | input | 64 | Request address |
| in_dac | input | 1 | 1 = dual address cycle (64-bit) |
| in_from_sec | input | 1 | 1 = request came from the secondary side |
| out_valid | output | 1 | Decode result valid |
| out_route | output | 2 | Route code |
| out_hit_pf | output | 1 | Prefetchable window was hit |
| out_hit_mmio | output | 1 | I/O window was hit |

## Verification
Register reads are combinational. The bench therefore samples cfg_rdata a short delay after it changes cfg_addr, in the same low clock phase. A register write takes effect at the rising edge on which cfg_wr_en is high. The decode result appears one rising edge after the strobe. The bench drives each request on a falling edge, drops the strobe on the next falling edge, and samples all four outputs at that same falling edge, which lies after the single register stage. The tests cover window edges on both sides of each bound, single- and dual-cycle addresses, and closed windows, with requests from each side.

// File: rtl/bwd_pkg.sv
package bwd_pkg;
  localparam int CFG_AW    = 8;
  localparam int CFG_DW    = 32;
  localparam int CFG_BW    = CFG_DW / 8;
  localparam int REQ_AW    = 64;
  localparam int LOW_AW    = 32;
  localparam int GRAN_W    = 20;
  localparam int HALF_W    = 16;
  localparam int FLD_W     = LOW_AW - GRAN_W;
  localparam int RSV_W     = HALF_W - FLD_W;
  localparam int UP_W      = REQ_AW - LOW_AW;

  localparam logic [CFG_AW-1:0] OFS_MMIO   = 8'h20;
  localparam logic [CFG_AW-1:0] OFS_PF     = 8'h24;
  localparam logic [CFG_AW-1:0] OFS_PF_UB  = 8'h28;
  localparam logic [CFG_AW-1:0] OFS_PF_UL  = 8'h2C;

  localparam logic [FLD_W-1:0] PF_BASE_RST = '1;
  localparam logic [FLD_W-1:0] PF_LIM_RST  = '0;

  typedef enum logic [1:0] {
    ROUTE_IGNORE = 2'b00,
    ROUTE_DOWN   = 2'b01,
    ROUTE_UP     = 2'b10
  } route_e;

  function automatic logic [CFG_DW-1:0] merge_bytes(
    input logic [CFG_DW-1:0] old_v,
    input logic [CFG_DW-1:0] new_v,
    input logic [CFG_BW-1:0] be
  );
    logic [CFG_DW-1:0] r;
    r = old_v;
    for (int i = 0; i < CFG_BW; i++) begin
      if (be[i]) r[i*8 +: 8] = new_v[i*8 +: 8];
    end
    return r;
  endfunction
endpackage

// File: rtl/bwd_cfg_regs.sv
module bwd_cfg_regs
  import bwd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CFG_AW-1:0] addr,
  input  logic [CFG_DW-1:0] wdata,
  input  logic [CFG_BW-1:0] be,
  output logic [CFG_DW-1:0] rdata,
  output logic [FLD_W-1:0]  mmio_base,
  output logic [FLD_W-1:0]  mmio_lim,
  output logic [FLD_W-1:0]  pf_base,
  output logic [FLD_W-1:0]  pf_lim,
  output logic [UP_W-1:0]   pf_base_up,
  output logic [UP_W-1:0]   pf_lim_up
);
  logic [FLD_W-1:0] mmio_base_q, mmio_base_d;
  logic [FLD_W-1:0] mmio_lim_q,  mmio_lim_d;
  logic [FLD_W-1:0] pf_base_q,   pf_base_d;
  logic [FLD_W-1:0] pf_lim_q,    pf_lim_d;
  logic [UP_W-1:0]  pf_bu_q,     pf_bu_d;
  logic [UP_W-1:0]  pf_lu_q,     pf_lu_d;

  logic [CFG_DW-1:0] mmio_word, pf_word, mmio_mrg, pf_mrg;
  logic              sel_mmio, sel_pf, sel_bu, sel_lu;

  assign mmio_word = {mmio_lim_q, {RSV_W{1'b0}}, mmio_base_q, {RSV_W{1'b0}}};
  assign pf_word   = {pf_lim_q,   {RSV_W{1'b0}}, pf_base_q,   {RSV_W{1'b0}}};

  assign sel_mmio = wr_en && (addr == OFS_MMIO);
  assign sel_pf   = wr_en && (addr == OFS_PF);
  assign sel_bu   = wr_en && (addr == OFS_PF_UB);
  assign sel_lu   = wr_en && (addr == OFS_PF_UL);

  assign mmio_mrg = merge_bytes(mmio_word, wdata, be);
  assign pf_mrg   = merge_bytes(pf_word,   wdata, be);

  always_comb begin
    mmio_base_d = mmio_base_q;
    mmio_lim_d  = mmio_lim_q;
    pf_base_d   = pf_base_q;
    pf_lim_d    = pf_lim_q;
    pf_bu_d     = pf_bu_q;
    pf_lu_d     = pf_lu_q;
    if (sel_mmio) begin
      mmio_base_d = mmio_mrg[RSV_W +: FLD_W];
      mmio_lim_d  = mmio_mrg[HALF_W+RSV_W +: FLD_W];
    end
    if (sel_pf) begin
      pf_base_d = pf_mrg[RSV_W +: FLD_W];
      pf_lim_d  = pf_mrg[HALF_W+RSV_W +: FLD_W];
    end
    if (sel_bu) pf_bu_d = merge_bytes(pf_bu_q, wdata, be);
    if (sel_lu) pf_lu_d = merge_bytes(pf_lu_q, wdata, be);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mmio_base_q <= '0;
      mmio_lim_q  <= '0;
      pf_base_q   <= PF_BASE_RST;
      pf_lim_q    <= PF_LIM_RST;
      pf_bu_q     <= '0;
      pf_lu_q     <= '0;
    end else if (wr_en) begin
      mmio_base_q <= mmio_base_d;
      mmio_lim_q  <= mmio_lim_d;
      pf_base_q   <= pf_base_d;
      pf_lim_q    <= pf_lim_d;
      pf_bu_q     <= pf_bu_d;
      pf_lu_q     <= pf_lu_d;
    end
  end

  always_comb begin
    unique case (addr)
      OFS_MMIO:  rdata = mmio_word;
      OFS_PF:    rdata = pf_word;
      OFS_PF_UB: rdata = pf_bu_q;
      OFS_PF_UL: rdata = pf_lu_q;
      default:   rdata = '0;
    endcase
  end

  assign mmio_base  = mmio_base_q;
  assign mmio_lim   = mmio_lim_q;
  assign pf_base    = pf_base_q;
  assign pf_lim     = pf_lim_q;
  assign pf_base_up = pf_bu_q;
  assign pf_lim_up  = pf_lu_q;
endmodule

// File: rtl/bwd_window.sv
module bwd_window
  import bwd_pkg::*;
#(
  parameter bit WIDE = 1'b1
) (
  input  logic [REQ_AW-1:0] addr,
  input  logic              dac,
  input  logic [FLD_W-1:0]  base_fld,
  input  logic [FLD_W-1:0]  lim_fld,
  input  logic [UP_W-1:0]   base_up,
  input  logic [UP_W-1:0]   lim_up,
  output logic              hit
);
  generate
    if (WIDE) begin : g_wide
      logic [REQ_AW-1:0] lo_bound, hi_bound;
      assign lo_bound = {base_up, base_fld, {GRAN_W{1'b0}}};
      assign hi_bound = {lim_up,  lim_fld,  {GRAN_W{1'b1}}};
      assign hit = (addr >= lo_bound) && (addr <= hi_bound);
    end else begin : g_narrow
      logic [LOW_AW-1:0] lo_bound, hi_bound;
      logic              up_unused;
      assign lo_bound  = {base_fld, {GRAN_W{1'b0}}};
      assign hi_bound  = {lim_fld,  {GRAN_W{1'b1}}};
      assign up_unused = ^{base_up, lim_up, addr[REQ_AW-1:LOW_AW]};
      assign hit = !dac && (addr[LOW_AW-1:0] >= lo_bound)
                        && (addr[LOW_AW-1:0] <= hi_bound);
    end
  endgenerate
endmodule

// File: rtl/bridge_win_decode.sv
module bridge_win_decode
  import bwd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  input  logic [CFG_BW-1:0] cfg_be,
  output logic [CFG_DW-1:0] cfg_rdata,
  input  logic              in_valid,
  input  logic [REQ_AW-1:0] in_addr,
  input  logic              in_dac,
  input  logic              in_from_sec,
  output logic              out_valid,
  output logic [1:0]        out_route,
  output logic              out_hit_pf,
  output logic              out_hit_mmio
);
  logic [FLD_W-1:0] mmio_base, mmio_lim, pf_base, pf_lim;
  logic [UP_W-1:0]  pf_base_up, pf_lim_up;
  logic [REQ_AW-1:0] eff_addr;
  logic hit_pf, hit_mmio, any_hit;

  bwd_cfg_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (cfg_wr_en),
    .addr       (cfg_addr),
    .wdata      (cfg_wdata),
    .be         (cfg_be),
    .rdata      (cfg_rdata),
    .mmio_base  (mmio_base),
    .mmio_lim   (mmio_lim),
    .pf_base    (pf_base),
    .pf_lim     (pf_lim),
    .pf_base_up (pf_base_up),
    .pf_lim_up  (pf_lim_up)
  );

  assign eff_addr = in_dac ? in_addr : {{UP_W{1'b0}}, in_addr[LOW_AW-1:0]};

  bwd_window #(.WIDE(1'b1)) u_win_pf (
    .addr     (eff_addr),
    .dac      (in_dac),
    .base_fld (pf_base),
    .lim_fld  (pf_lim),
    .base_up  (pf_base_up),
    .lim_up   (pf_lim_up),
    .hit      (hit_pf)
  );

  bwd_window #(.WIDE(1'b0)) u_win_mmio (
    .addr     (eff_addr),
    .dac      (in_dac),
    .base_fld (mmio_base),
    .lim_fld  (mmio_lim),
    .base_up  ('0),
    .lim_up   ('0),
    .hit      (hit_mmio)
  );

  assign any_hit = hit_pf || hit_mmio;

  route_e route_d;
  logic   valid_d, pf_d, mmio_d;
  logic   valid_q, pf_q, mmio_q;
  route_e route_q;

  always_comb begin
    valid_d = in_valid;
    pf_d    = in_valid && hit_pf;
    mmio_d  = in_valid && hit_mmio;
    route_d = ROUTE_IGNORE;
    if (in_valid) begin
      if (in_from_sec) route_d = any_hit ? ROUTE_IGNORE : ROUTE_UP;
      else             route_d = any_hit ? ROUTE_DOWN   : ROUTE_IGNORE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      pf_q    <= 1'b0;
      mmio_q  <= 1'b0;
      route_q <= ROUTE_IGNORE;
    end else begin
      valid_q <= valid_d;
      pf_q    <= pf_d;
      mmio_q  <= mmio_d;
      route_q <= route_d;
    end
  end

  assign out_valid    = valid_q;
  assign out_route    = route_q;
  assign out_hit_pf   = pf_q;
  assign out_hit_mmio = mmio_q;
endmodule

// File: rtl/bwd_checker.sv
module bwd_checker
  import bwd_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [CFG_AW-1:0] cfg_addr,
  input logic [CFG_DW-1:0] cfg_rdata,
  input logic              in_valid,
  input logic              in_dac,
  input logic              in_from_sec,
  input logic              out_valid,
  input logic [1:0]        out_route,
  input logic              out_hit_pf,
  input logic              out_hit_mmio
);
  assert_rsv_nibbles_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr == OFS_MMIO || cfg_addr == OFS_PF) |->
      (cfg_rdata[RSV_W-1:0] == '0 && cfg_rdata[HALF_W +: RSV_W] == '0));

  assert_dac_no_mmio_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_dac) |=> !out_hit_mmio);

  assert_no_code11_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_route != 2'b11);

  assert_primary_route_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_from_sec) |=>
      (out_route == ((out_hit_pf || out_hit_mmio) ? 2'b01 : 2'b00)));

  assert_secondary_route_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_from_sec) |=>
      (out_route == ((out_hit_pf || out_hit_mmio) ? 2'b00 : 2'b10)));

  assert_valid_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && out_route == 2'b00 && !out_hit_pf && !out_hit_mmio));
endmodule

bind bridge_win_decode bwd_checker chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_addr     (cfg_addr),
  .cfg_rdata    (cfg_rdata),
  .in_valid     (in_valid),
  .in_dac       (in_dac),
  .in_from_sec  (in_from_sec),
  .out_valid    (out_valid),
  .out_route    (out_route),
  .out_hit_pf   (out_hit_pf),
  .out_hit_mmio (out_hit_mmio)
);

// File: tb/bridge_win_decode_tb.sv
module bridge_win_decode_tb_top;
  logic        clk;
  logic        rst_n;
  logic        cfg_wr_en;
  logic [7:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_rdata;
  logic        in_valid;
  logic [63:0] in_addr;
  logic        in_dac;
  logic        in_from_sec;
  logic        out_valid;
  logic [1:0]  out_route;
  logic        out_hit_pf;
  logic        out_hit_mmio;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  bridge_win_decode dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_be(cfg_be), .cfg_rdata(cfg_rdata),
    .in_valid(in_valid), .in_addr(in_addr), .in_dac(in_dac),
    .in_from_sec(in_from_sec), .out_valid(out_valid), .out_route(out_route),
    .out_hit_pf(out_hit_pf), .out_hit_mmio(out_hit_mmio)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d; cfg_be = be;
    @(negedge clk);
    cfg_wr_en = 1'b0; cfg_be = '0;
  endtask

  task automatic cfg_check(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    cfg_addr = a;
    #1;
    check(req, cfg_rdata, exp);
  endtask

  task automatic decode(input string req, input logic [63:0] a, input logic dac,
                        input logic sec, input logic [1:0] exp_route,
                        input logic exp_pf, input logic exp_mmio);
    @(negedge clk);
    in_valid = 1'b1; in_addr = a; in_dac = dac; in_from_sec = sec;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, out_valid, 1);
    check({req, " route"}, out_route, exp_route);
    check({req, " pf"}, out_hit_pf, exp_pf);
    check({req, " mmio"}, out_hit_mmio, exp_mmio);
  endtask

  task automatic t_reset;
    check("R1 out_valid", out_valid, 0);
    check("R1 out_route", out_route, 0);
    cfg_check("R1 mmio dword", 8'h20, 32'h0000_0000);
    cfg_check("R1 pf dword", 8'h24, 32'h0000_FFF0);
    cfg_check("R1 pf upper base", 8'h28, 32'h0);
    cfg_check("R1 pf upper limit", 8'h2C, 32'h0);
    decode("R1 R5 bottom MB top", 64'h000F_FFFF, 0, 0, 2'b01, 0, 1);
    decode("R1 R5 above bottom MB", 64'h0010_0000, 0, 0, 2'b00, 0, 0);
  endtask

  task automatic t_regs;
    cfg_write(8'h20, 32'h1255_123F, 4'hF);
    cfg_check("R2 nibble dropped", 8'h20, 32'h1250_1230);
    cfg_write(8'h20, 32'h0000_1100, 4'b0010);
    cfg_check("R4 single byte", 8'h20, 32'h1250_1130);
    cfg_write(8'h20, 32'h0000_1230, 4'b0011);
    cfg_check("R4 restore", 8'h20, 32'h1250_1230);
    cfg_write(8'h2C, 32'h0000_0001, 4'hF);
    cfg_write(8'h2C, 32'hAB00_0000, 4'b1000);
    cfg_check("R3 R4 upper limit byte", 8'h2C, 32'hAB00_0001);
    cfg_write(8'h2C, 32'h0000_0001, 4'hF);
    cfg_check("R3 upper limit", 8'h2C, 32'h0000_0001);
  endtask

  task automatic t_mmio;
    decode("R5 R10 base edge", 64'h1230_0000, 0, 0, 2'b01, 0, 1);
    decode("R5 R10 below base", 64'h122F_FFFF, 0, 0, 2'b00, 0, 0);
    decode("R5 R10 limit edge", 64'h125F_FFFF, 0, 0, 2'b01, 0, 1);
    decode("R5 R10 above limit", 64'h1260_0000, 0, 0, 2'b00, 0, 0);
    decode("R7 dac misses mmio", 64'h0000_0000_1240_0000, 1, 0, 2'b00, 0, 0);
    decode("R8 sac ignores upper bits", 64'hFFFF_FFFF_1240_0000, 0, 0, 2'b01, 0, 1);
    decode("R11 sec hit ignored", 64'h1240_0000, 0, 1, 2'b00, 0, 1);
    decode("R11 sec miss upstream", 64'h2000_0000, 0, 1, 2'b10, 0, 0);
  endtask

  task automatic t_pf;
    cfg_write(8'h24, 32'h8FF0_8000, 4'hF);
    cfg_write(8'h28, 32'h0000_0001, 4'hF);
    decode("R5 pf dac base", 64'h1_8000_0000, 1, 0, 2'b01, 1, 0);
    decode("R5 pf dac limit", 64'h1_8FFF_FFFF, 1, 0, 2'b01, 1, 0);
    decode("R5 pf dac above", 64'h1_9000_0000, 1, 0, 2'b00, 0, 0);
    decode("R8 sac upper base nonzero", 64'h8000_0000, 0, 0, 2'b00, 0, 0);
    cfg_write(8'h28, 32'h0, 4'hF);
    decode("R8 sac hits with zero upper", 64'h8000_0000, 0, 0, 2'b01, 1, 0);
    decode("R8 sac high address", 64'hF000_0000, 0, 0, 2'b01, 1, 0);
    decode("R5 pf dac past limit", 64'h2_0000_0000, 1, 0, 2'b00, 0, 0);
    decode("R11 pf sec ignored", 64'h8000_0000, 0, 1, 2'b00, 1, 0);
  endtask

  task automatic t_disable;
    cfg_write(8'h20, 32'h1250_1300, 4'hF);
    decode("R6 mmio closed primary", 64'h1240_0000, 0, 0, 2'b00, 0, 0);
    decode("R6 mmio closed secondary", 64'h1240_0000, 0, 1, 2'b10, 0, 0);
    cfg_write(8'h28, 32'h0000_0002, 4'hF);
    decode("R6 pf upper base above limit", 64'h1_8000_0000, 1, 0, 2'b00, 0, 0);
  endtask

  task automatic t_idle;
    @(negedge clk);
    check("R12 idle valid", out_valid, 0);
    check("R12 idle route", out_route, 0);
    check("R12 idle flags", {out_hit_pf, out_hit_mmio}, 0);
  endtask

  initial begin
    rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_addr = '0; cfg_wdata = '0; cfg_be = '0;
    in_valid = 1'b0; in_addr = '0; in_dac = 1'b0; in_from_sec = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_mmio();
    t_pf();
    t_disable();
    t_idle();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule